// File: doc/BRIEF.md
# Cascaded Interrupt Aggregator with Set/Clear Controls

This block gathers up to sixteen level-sensitive board interrupt sources into a single active-low request line for a host processor. Each source has a pending bit plus two independent gating bits, an enable and a mask. A source pulls the combined line low only while all three of its bits are 1.

A small synchronous register port reaches a status register and the two gating registers. The gating registers have no plain write address. Each has one address where writing 1s sets bits and another where writing 1s clears bits, so software can change one bit without a read-modify-write. Writing 1s to the status register acknowledges pending bits. Registers are 16 bits wide and placed on 32-bit spacing. The write and read paths decode the address into one of six register selects: status, enable-set, enable-clear, mask-set, mask-clear and none. A write strobe then moves the addressed register from its held value to its updated value on the next clock. A read strobe moves the read-data register to the value at the selected address on the next clock.

Top module: `irq_cascade_ctl`

## Requirements
- R1: After reset the enable, mask and pending registers read 0, bus_rdata is 0 and host_irq_n is 1.
- R2: A pending bit becomes 1 at the first clock edge where its source input is 1 and its enable bit is 1. It stays 1 until acknowledged. While the enable bit is 0 the source input never sets it.
- R3: Writing to the status address (byte offset 0x00) clears, at the next edge, every pending bit written as 1. Bits written as 0 keep their value. If the source is still 1 and enabled, the bit is set again one edge after the clearing edge.
- R4: Writing to the enable-set address (0x04) sets the enable bits written as 1. Writing to the enable-clear address (0x08) clears the enable bits written as 1. Bits written as 0 keep their value.
- R5: The mask register follows the same write-one rules at its set address (0x0C) and clear address (0x10).
- R6: host_irq_n is 0 exactly while some bit has pending, enable and mask all equal to 1. It follows the registers with no extra cycle of delay.
- R7: A read strobe loads bus_rdata at the next edge with the value the addressed register held before that edge. Both the set and clear addresses of a control return that control's register. An address with bits [1:0] not zero, or at offset 0x14 or above, returns 0. bus_rdata holds its value between reads.
- R8: Writing 0xFFFF to the enable-clear, mask-clear and status addresses in turn leaves every enable bit, mask bit and pending bit at 0, and host_irq_n at 1.
- R9: A mask bit of 0 does not stop its pending bit from latching. Setting the mask bit later, with the pending and enable bits still 1, drives host_irq_n to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | NSRC (16) | Write data |
| bus_rdata | output | NSRC (16) | Registered read data |
| src_in | input | NSRC (16) | Level interrupt sources, active high |
| host_irq_n | output | 1 | Combined request, active low |

## Verification
Register writes and source sampling act at the first edge after the stimulus. host_irq_n reflects that edge at once, so it is due half a cycle after the edge. Read data is due one edge after the read strobe. An acknowledged bit whose source is still high comes back one edge later still. Inputs change on falling edges. The bench's reference model updates on rising edges, and every output comparison falls on the following falling edge, where each of these results is due. Directed checks wait exactly one falling edge after a write or read before they compare.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    // Word index of each register (byte offset divided by four)
    localparam int IDX_STATUS = 0;
    localparam int IDX_EN_SET = 1;
    localparam int IDX_EN_CLR = 2;
    localparam int IDX_MK_SET = 3;
    localparam int IDX_MK_CLR = 4;

    typedef enum logic [2:0] {
        SEL_STATUS,
        SEL_EN_SET,
        SEL_EN_CLR,
        SEL_MK_SET,
        SEL_MK_CLR,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/irq_cascade_decode.sv
module irq_cascade_decode
    import irq_cascade_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              aligned;

    assign widx    = addr[ADDR_W-1:2];
    assign aligned = (addr[1:0] == 2'b00);

    always_comb begin
        sel = SEL_NONE;
        if (aligned) begin
            unique case (widx)
                WIDX_W'(IDX_STATUS): sel = SEL_STATUS;
                WIDX_W'(IDX_EN_SET): sel = SEL_EN_SET;
                WIDX_W'(IDX_EN_CLR): sel = SEL_EN_CLR;
                WIDX_W'(IDX_MK_SET): sel = SEL_MK_SET;
                WIDX_W'(IDX_MK_CLR): sel = SEL_MK_CLR;
                default:             sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_cascade_setclr.sv
module irq_cascade_setclr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] bits,
    output logic [W-1:0] q
);
    logic [W-1:0] q_r;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (set_stb) begin
            q_r <= q_r | bits;
        end else if (clr_stb) begin
            q_r <= q_r & ~bits;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/irq_cascade_pending.sv
module irq_cascade_pending #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src,
    input  logic [W-1:0] en,
    input  logic         ack_stb,
    input  logic [W-1:0] ack_bits,
    output logic [W-1:0] pend
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (ack_stb && ack_bits[i]) begin
                bit_q <= 1'b0;
            end else if (src[i] && en[i]) begin
                bit_q <= 1'b1;
            end
        end
        assign pend[i] = bit_q;
    end
endmodule

// File: rtl/irq_cascade_ctl.sv
module irq_cascade_ctl
    import irq_cascade_pkg::*;
#(
    parameter int NSRC   = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NSRC-1:0]   bus_wdata,
    output logic [NSRC-1:0]   bus_rdata,
    input  logic [NSRC-1:0]   src_in,
    output logic              host_irq_n
);
    reg_sel_e        sel;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] rd_mux;
    logic [NSRC-1:0] rdata_q;

    irq_cascade_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    irq_cascade_setclr #(.W(NSRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_wr && (sel == SEL_EN_SET)),
        .clr_stb (bus_wr && (sel == SEL_EN_CLR)),
        .bits    (bus_wdata),
        .q       (en_q)
    );

    irq_cascade_setclr #(.W(NSRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (bus_wr && (sel == SEL_MK_SET)),
        .clr_stb (bus_wr && (sel == SEL_MK_CLR)),
        .bits    (bus_wdata),
        .q       (mask_q)
    );

    irq_cascade_pending #(.W(NSRC)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src_in),
        .en       (en_q),
        .ack_stb  (bus_wr && (sel == SEL_STATUS)),
        .ack_bits (bus_wdata),
        .pend     (pend_q)
    );

    always_comb begin
        unique case (sel)
            SEL_STATUS:             rd_mux = pend_q;
            SEL_EN_SET, SEL_EN_CLR: rd_mux = en_q;
            SEL_MK_SET, SEL_MK_CLR: rd_mux = mask_q;
            default:                rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign host_irq_n = ~|(pend_q & en_q & mask_q);
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
    parameter int NSRC   = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   bus_wdata,
    input logic [NSRC-1:0]   bus_rdata,
    input logic [NSRC-1:0]   src_in,
    input logic              host_irq_n,
    input logic [NSRC-1:0]   en,
    input logic [NSRC-1:0]   mask,
    input logic [NSRC-1:0]   pend
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(8'h04);
    localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_MK_SET = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_MK_CLR = ADDR_W'(8'h10);

    logic is_stat_wr;
    assign is_stat_wr = bus_wr && (bus_addr == A_STATUS);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (en == '0 && mask == '0 && pend == '0 && bus_rdata == '0));

    p_disabled_no_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0 && !is_stat_wr && pend == '0) |=> pend == '0);

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        is_stat_wr |=> (pend & $past(bus_wdata)) == '0);

    p_pend_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !is_stat_wr |=> (pend & $past(pend)) == $past(pend));

    p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_SET) |=> (en & $past(bus_wdata)) == $past(bus_wdata));

    p_en_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_EN_CLR) |=> (en & $past(bus_wdata)) == '0);

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MK_SET) |=> (mask & $past(bus_wdata)) == $past(bus_wdata));

    p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MK_CLR) |=> (mask & $past(bus_wdata)) == '0);

    p_no_mask_no_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> host_irq_n);

    p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr[1:0] != 2'b00 || bus_addr > A_MK_CLR)) |=> bus_rdata == '0);

    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    p_en_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (bus_addr == A_EN_SET || bus_addr == A_EN_CLR)) |=> $stable(en));

    logic unused_ok;
    assign unused_ok = ^src_in;
endmodule

bind irq_cascade_ctl irq_cascade_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .src_in     (src_in),
    .host_irq_n (host_irq_n),
    .en         (en_q),
    .mask       (mask_q),
    .pend       (pend_q)
);

// File: tb/irq_cascade_ctl_tb.sv
module irq_cascade_ctl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 16;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [NSRC-1:0]   bus_wdata = '0;
    logic [NSRC-1:0]   bus_rdata;
    logic [NSRC-1:0]   src_in = '0;
    logic              host_irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    int m_en = 0, m_mask = 0, m_pend = 0, m_rdata = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cascade_ctl #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .host_irq_n(host_irq_n)
    );

    function automatic int model_read(int a);
        if ((a % 4) != 0) return 0;
        case (a / 4)
            0: return m_pend;
            1, 2: return m_en;
            3, 4: return m_mask;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int a, w, s, np;
        if (!rst_n) begin
            m_en = 0; m_mask = 0; m_pend = 0; m_rdata = 0;
        end else begin
            a = int'(bus_addr); w = int'(bus_wdata); s = int'(src_in);
            if (bus_rd) m_rdata = model_read(a);
            np = m_pend;
            for (int i = 0; i < NSRC; i++) begin
                if (bus_wr && a == 0 && w[i]) np[i] = 1'b0;
                else if (s[i] && m_en[i]) np[i] = 1'b1;
            end
            m_pend = np;
            if (bus_wr && a == 4)  m_en   = m_en | w;
            if (bus_wr && a == 8)  m_en   = m_en & ~w;
            if (bus_wr && a == 12) m_mask = m_mask | w;
            if (bus_wr && a == 16) m_mask = m_mask & ~w;
        end
    end

    // Every-cycle comparison against the model (R6, R7)
    always @(negedge clk) begin
        bit exp_irq;
        if (rst_n && !finished) begin
            exp_irq = ((m_pend & m_en & m_mask) == 0);
            n_checks++;
            if (host_irq_n !== exp_irq) begin
                n_fail++;
                $display("FAIL R6 model host_irq_n actual=%0b expected=%0b", host_irq_n, exp_irq);
            end
            n_checks++;
            if (int'(bus_rdata) != m_rdata) begin
                n_fail++;
                $display("FAIL R7 model bus_rdata actual=%h expected=%h", bus_rdata, m_rdata[15:0]);
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = NSRC'(d);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input int a, output int d);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = int'(bus_rdata);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", int'(bus_rdata), 0);
        check("R1 irq", int'(host_irq_n), 1);
        rd(0, v);  check("R1 status", v, 0);
        rd(4, v);  check("R1 enable", v, 0);
        rd(12, v); check("R1 mask", v, 0);

        // R2 disabled source never latches
        src_in = 16'h0001;
        repeat (3) @(negedge clk);
        rd(0, v); check("R2 disabled", v, 0);

        // R4 enable set, readable from both addresses (R7)
        wr(4, 16'h0003);
        rd(4, v); check("R4 set read", v, 3);
        rd(8, v); check("R7 clr-addr read", v, 3);

        // R2 / R9 latch while masked, no irq
        @(negedge clk);
        rd(0, v); check("R2 latched", v, 1);
        check("R9 masked irq", int'(host_irq_n), 1);

        // R5 / R9 unmask asserts irq
        wr(12, 16'h0001);
        check("R9 unmask irq", int'(host_irq_n), 0);
        rd(16, v); check("R5 mask read", v, 1);

        // R3 write 0 has no effect
        wr(0, 16'h0000);
        rd(0, v); check("R3 zero write", v, 1);

        // R3 ack with source still high: cleared then set again
        wr(0, 16'h0001);
        check("R3 cleared", int'(host_irq_n), 1);
        @(negedge clk);
        check("R3 re-set", int'(host_irq_n), 0);

        // R3 ack with source low
        src_in = 16'h0000;
        wr(0, 16'h0001);
        rd(0, v); check("R3 acked", v, 0);
        check("R6 idle irq", int'(host_irq_n), 1);

        // R4 clear only written bits
        wr(8, 16'h0001);
        rd(4, v); check("R4 clear", v, 2);
        // R5 clear
        wr(12, 16'h0006);
        wr(16, 16'h0004);
        rd(12, v); check("R5 clear", v, 3);

        // R7 unmapped and misaligned
        rd(20, v);  check("R7 unmapped", v, 0);
        rd(8'h40, v); check("R7 high", v, 0);
        rd(5, v);   check("R7 misaligned", v, 0);
        @(negedge clk);
        check("R7 hold", int'(bus_rdata), 0);

        // R8 clear-all sequence
        wr(4, 16'hFFFF); wr(12, 16'hFFFF);
        src_in = 16'hA5A5;
        @(negedge clk);
        src_in = 16'h0000;
        check("R8 pre irq", int'(host_irq_n), 0);
        wr(8, 16'hFFFF); wr(16, 16'hFFFF); wr(0, 16'hFFFF);
        rd(0, v);  check("R8 status", v, 0);
        rd(4, v);  check("R8 enable", v, 0);
        rd(12, v); check("R8 mask", v, 0);
        check("R8 irq", int'(host_irq_n), 1);

        // Random traffic checked against the model each cycle
        for (int k = 0; k < 2000; k++) begin
            bus_wr = ($urandom_range(0, 3) == 0);
            bus_rd = !bus_wr && ($urandom_range(0, 2) == 0);
            bus_addr = ADDR_W'($urandom_range(0, 5) * 4 + (($urandom_range(0, 15) == 0) ? 1 : 0));
            bus_wdata = NSRC'($urandom);
            if ($urandom_range(0, 3) == 0) src_in = NSRC'($urandom);
            @(negedge clk);
        end
        bus_wr = 1'b0; bus_rd = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule